// File: doc/BRIEF.md
# Multicast hash address filter

This block decides whether a received frame is kept, based only on its destination address. It watches the receive byte stream, collects the first six bytes after a start-of-frame mark, and one cycle after the sixth byte it gives a one-cycle verdict strobe together with an accept flag. The MAC framing around it (preamble, length, frame check) lives elsewhere.

There are four ways a frame is accepted. Any frame is accepted in promiscuous mode. The all-ones broadcast address is always accepted. An individual (unicast) address is accepted when it equals the configured station address. A group (multicast) address is hashed with a reflected CRC-32, and the top six bits of the hash pick one bit of a 64-bit filter table. That table is loaded as four 16-bit words through a simple write port. Software must leave the table alone while a frame's address is being examined.

Top module: `mcast_addr_filter`

## Requirements
- R1: After reset `verdict_valid` is 0 and all four filter words are 0, so a non-broadcast multicast frame is rejected until the table is loaded.
- R2: `verdict_valid` is 1 for exactly one cycle, the cycle after the one in which the sixth address byte is taken, and `verdict_accept` is meaningful in that cycle.
- R3: A byte taken with `sof`=1 is address byte 0 and restarts any frame in progress. Bytes after the sixth, and bytes arriving with no frame open (for example straight after reset), produce no verdict.
- R4: Address byte k sits at bits 8k+7:8k of the 48-bit address and of `station_addr`. An address whose byte 0 bit 0 is 0 is unicast, and it is accepted exactly when it equals `station_addr` (promiscuous mode off).
- R5: For a multicast address the hash is a CRC-32 taken least-significant bit first over bytes 0 to 5. The register starts at 0xFFFFFFFF, uses the reflected polynomial 0xEDB88320 and has no final inversion. The index is CRC bits 31:26.
- R6: Index bits 5:4 choose the filter word and index bits 3:0 choose the bit in that word. A non-broadcast multicast frame is accepted exactly when that bit is 1.
- R7: A cycle with `flt_wr_en`=1 replaces filter word `flt_wr_sel` with `flt_wr_data` at that clock edge. The other words do not change.
- R8: With every filter word 0xFFFF, every multicast frame is accepted. With every word 0, every non-broadcast multicast frame is rejected.
- R9: The address 0xFFFFFFFFFFFF is accepted whatever the filter holds.
- R10: With `promisc`=1, every frame is accepted whatever its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| promisc | input | 1 | Promiscuous mode: accept all frames |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| flt_wr_en | input | 1 | Write strobe for one filter word |
| flt_wr_sel | input | 2 | Filter word number being written |
| flt_wr_data | input | 16 | New value of that filter word |
| byte_valid | input | 1 | A receive byte is present this cycle |
| sof | input | 1 | The present byte is address byte 0 |
| byte_data | input | 8 | Receive byte |
| verdict_valid | output | 1 | One-cycle strobe: verdict is ready |
| verdict_accept | output | 1 | 1 when the frame is accepted |

## Verification
Directed frames cover each acceptance path on its own. These are a matching and a mismatching unicast, broadcast against an empty table, a single-bit table that accepts one multicast address and rejects another with a different index, all-ones and all-zeros tables, and promiscuous mode over addresses that would otherwise be rejected. Together they show which path produced each verdict. Separate stimulus sends stray bytes with no frame open, trailing bytes after the address and an aborted frame restarted by `sof`, to confirm that only one verdict comes out and that it comes at the right cycle. Random frames with a random table, random multicast/unicast mix and occasional promiscuous mode are compared against a bench CRC model, which exercises the index-to-word and index-to-bit mapping across all 64 positions.

// File: rtl/maf_pkg.sv
`timescale 1ns/1ps
// Shared constants and the CRC step for the address filter.
// Assumes a 32-bit reflected CRC fed least-significant bit first.
package maf_pkg;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

    // Advance the CRC register over one byte, bit 0 first.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                  input logic [7:0]       d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/maf_addr_capture.sv
`timescale 1ns/1ps
// Collects the destination address bytes of a frame and runs the CRC
// over them as they arrive. On the cycle the last address byte is
// present, it presents the complete address and hash index.
// Assumes ADDR_BYTES >= 2 and that sof is only honoured with byte_valid.
module maf_addr_capture #(
    parameter  int ADDR_BYTES = 6,
    parameter  int IDX_W      = 6,
    localparam int ADDR_W     = 8 * ADDR_BYTES,
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic              sof,
    input  logic [7:0]        byte_data,
    output logic              last_byte,
    output logic [ADDR_W-1:0] addr_full,
    output logic [IDX_W-1:0]  hash_idx
);
    import maf_pkg::*;

    logic [CNT_W-1:0]  cnt_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_next;
    logic [ADDR_W-9:0] addr_q;
    logic              take;

    // Byte acceptance, last-byte detect and the combined address/hash view.
    always_comb begin
        take      = byte_valid && (sof || (cnt_q < CNT_W'(ADDR_BYTES)));
        crc_next  = crc_byte(sof ? CRC_INIT : crc_q, byte_data);
        last_byte = byte_valid && !sof && (cnt_q == CNT_W'(ADDR_BYTES - 1));
        addr_full = {byte_data, addr_q};
        hash_idx  = crc_next[CRC_W-1 -: IDX_W];
    end

    // Byte counter and running CRC; the count rests at ADDR_BYTES when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(ADDR_BYTES);
            crc_q <= CRC_INIT;
        end else if (take) begin
            cnt_q <= sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
            crc_q <= crc_next;
        end
    end

    // One storage byte per address position except the last.
    for (genvar b = 0; b < ADDR_BYTES - 1; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                addr_q[8*b +: 8] <= '0;
            else if (take && ((sof && b == 0) || (!sof && cnt_q == CNT_W'(b))))
                addr_q[8*b +: 8] <= byte_data;
        end
    end

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(ADDR_BYTES));
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(ADDR_BYTES) && !(byte_valid && sof)) |=> cnt_q == CNT_W'(ADDR_BYTES));
    a_r3_sof_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && sof) |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/maf_hash_table.sv
`timescale 1ns/1ps
// Logical address filter: NUM_WORDS words of WORD_W bits, written one
// word at a time, read as a single bit picked by word and bit number.
// Assumes NUM_WORDS >= 2 and the table is not written mid-address.
module maf_hash_table #(
    parameter  int NUM_WORDS = 4,
    parameter  int WORD_W    = 16,
    localparam int SEL_W     = $clog2(NUM_WORDS),
    localparam int BIT_W     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_word,
    input  logic [BIT_W-1:0]  rd_bit,
    output logic              hit
);
    logic [WORD_W-1:0] words [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        // Holds one filter word; cleared by reset, replaced on its write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[w] <= '0;
            else if (wr_en && wr_sel == SEL_W'(w))
                words[w] <= wr_data;
        end

        a_r7_word_written: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_W'(w)) |=> words[w] == $past(wr_data));
        a_r7_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == SEL_W'(w)) |=> $stable(words[w]));
    end

    // Selected bit of the selected word.
    always_comb hit = words[rd_word][rd_bit];
endmodule

// File: rtl/mcast_addr_filter.sv
`timescale 1ns/1ps
// Destination address filter for received frames. Captures the address
// bytes, then one cycle after the last one strobes a verdict: accept on
// promiscuous mode, broadcast, station match (unicast) or a set hash bit
// (multicast). Assumes the filter table is stable while a frame's
// address is being received.
module mcast_addr_filter #(
    parameter  int ADDR_BYTES = 6,
    parameter  int NUM_WORDS  = 4,
    parameter  int WORD_W     = 16,
    localparam int ADDR_W     = 8 * ADDR_BYTES,
    localparam int SEL_W      = $clog2(NUM_WORDS),
    localparam int BIT_W      = $clog2(WORD_W),
    localparam int IDX_W      = SEL_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              promisc,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              flt_wr_en,
    input  logic [SEL_W-1:0]  flt_wr_sel,
    input  logic [WORD_W-1:0] flt_wr_data,
    input  logic              byte_valid,
    input  logic              sof,
    input  logic [7:0]        byte_data,
    output logic              verdict_valid,
    output logic              verdict_accept
);
    logic              last_byte;
    logic [ADDR_W-1:0] addr_full;
    logic [IDX_W-1:0]  hash_idx;
    logic              mc_hit;
    logic              is_mcast;
    logic              is_bcast;
    logic              accept_d;

    maf_addr_capture #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .sof        (sof),
        .byte_data  (byte_data),
        .last_byte  (last_byte),
        .addr_full  (addr_full),
        .hash_idx   (hash_idx)
    );

    maf_hash_table #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (flt_wr_en),
        .wr_sel  (flt_wr_sel),
        .wr_data (flt_wr_data),
        .rd_word (hash_idx[IDX_W-1 -: SEL_W]),
        .rd_bit  (hash_idx[BIT_W-1:0]),
        .hit     (mc_hit)
    );

    // Classify the address and combine the acceptance paths.
    always_comb begin
        is_mcast = addr_full[0];
        is_bcast = &addr_full;
        accept_d = promisc || is_bcast || (is_mcast ? mc_hit : (addr_full == station_addr));
    end

    // Register the verdict strobe and result one cycle after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end else begin
            verdict_valid <= last_byte;
            if (last_byte) verdict_accept <= accept_d;
        end
    end

    a_r2_verdict_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte |=> verdict_valid);
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);
    a_r10_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && promisc) |=> verdict_accept);
    a_r9_broadcast_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && is_bcast) |=> verdict_accept);
    a_r4_unicast_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && !promisc && !is_mcast && addr_full != station_addr) |=> !verdict_accept);
endmodule

// File: tb/sim_mcast_addr_filter.sv
`timescale 1ns/1ps
module sim_mcast_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        promisc = 1'b0;
    logic [47:0] station_addr = 48'h0;
    logic        flt_wr_en = 1'b0;
    logic [1:0]  flt_wr_sel = 2'd0;
    logic [15:0] flt_wr_data = 16'h0;
    logic        byte_valid = 1'b0;
    logic        sof = 1'b0;
    logic [7:0]  byte_data = 8'h0;
    logic        verdict_valid;
    logic        verdict_accept;

    int total = 0;
    int bad = 0;
    logic [15:0] filt_m [4];

    always #2.5 clk = ~clk;

    mcast_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .promisc(promisc), .station_addr(station_addr),
        .flt_wr_en(flt_wr_en), .flt_wr_sel(flt_wr_sel), .flt_wr_data(flt_wr_data),
        .byte_valid(byte_valid), .sof(sof), .byte_data(byte_data),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
    );

    // Reference hash: LSB-first CRC-32, reflected poly, no final inversion.
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < 48; k++) begin
            logic fb = c[0] ^ a[k];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c[31:26];
    endfunction

    function automatic logic ref_accept(input logic [47:0] a, input logic p);
        logic [5:0] ix;
        if (p || a == 48'hFFFFFFFFFFFF) return 1'b1;
        if (!a[0]) return a == station_addr;
        ix = ref_idx(a);
        return filt_m[ix[5:4]][ix[3:0]];
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr_word(input int w, input logic [15:0] d);
        @(negedge clk);
        flt_wr_en = 1'b1; flt_wr_sel = 2'(w); flt_wr_data = d;
        filt_m[w] = d;
        @(negedge clk);
        flt_wr_en = 1'b0;
    endtask

    task automatic load_all(input logic [15:0] d);
        for (int w = 0; w < 4; w++) wr_word(w, d);
    endtask

    // Send six address bytes plus trailing bytes; check the single verdict.
    task automatic run_frame(input string req, input logic [47:0] a, input int trailing);
        logic exp_acc;
        exp_acc = ref_accept(a, promisc);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; sof = (i == 0); byte_data = a[8*i +: 8];
        end
        @(negedge clk);
        chk({req, " valid"}, 32'(verdict_valid), 32'd1);
        chk({req, " accept"}, 32'(verdict_accept), 32'(exp_acc));
        sof = 1'b0;
        byte_valid = (trailing > 0);
        byte_data = 8'($urandom);
        for (int t = 0; t < trailing; t++) begin
            @(negedge clk);
            byte_data = 8'($urandom);
            chk("R3 no verdict on trailing byte", 32'(verdict_valid), 32'd0);
        end
        byte_valid = 1'b0;
        @(negedge clk);
        chk("R2 one-cycle strobe", 32'(verdict_valid), 32'd0);
    endtask

    function automatic logic [47:0] rand_mcast();
        logic [47:0] a = {16'($urandom), 32'($urandom)};
        a[0] = 1'b1;
        if (a == 48'hFFFFFFFFFFFF) a[47] = 1'b0;
        return a;
    endfunction

    initial begin
        #(150000 * 5);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [47:0] a, b;
        logic [5:0]  ia, ib;
        void'($urandom(32'h5EED1234));
        for (int w = 0; w < 4; w++) filt_m[w] = 16'h0;
        repeat (4) @(negedge clk);
        chk("R1 reset strobe low", 32'(verdict_valid), 32'd0);
        rst_n = 1'b1;
        station_addr = 48'h665544332210;

        // R3: stray bytes with no frame open
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; sof = 1'b0; byte_data = 8'(i);
            if (i > 0) chk("R3 stray byte ignored", 32'(verdict_valid), 32'd0);
        end
        byte_valid = 1'b0;
        @(negedge clk);
        chk("R3 stray byte ignored", 32'(verdict_valid), 32'd0);

        run_frame("R1 empty table rejects multicast", rand_mcast(), 0);
        run_frame("R4 unicast match", station_addr, 0);
        run_frame("R4 unicast mismatch", station_addr ^ 48'h010000000000, 0);
        run_frame("R9 broadcast", 48'hFFFFFFFFFFFF, 0);

        // R5/R6: single bit set for one address, another index rejected
        a = rand_mcast();
        ia = ref_idx(a);
        do begin b = rand_mcast(); ib = ref_idx(b); end while (ib == ia);
        wr_word(int'(ia[5:4]), 16'(1) << ia[3:0]);
        run_frame("R5 hashed bit accepts", a, 0);
        run_frame("R6 other index rejects", b, 0);
        run_frame("R9 broadcast with table", 48'hFFFFFFFFFFFF, 2);

        // R7: overwrite the word, the address is now rejected
        wr_word(int'(ia[5:4]), ~(16'(1) << ia[3:0]));
        run_frame("R7 word rewritten", a, 0);

        load_all(16'hFFFF);
        for (int n = 0; n < 8; n++) run_frame("R8 all ones accepts", rand_mcast(), 0);
        load_all(16'h0000);
        for (int n = 0; n < 8; n++) run_frame("R8 all zeros rejects", rand_mcast(), 1);

        promisc = 1'b1;
        run_frame("R10 promisc unicast", station_addr ^ 48'h00000000FF00, 0);
        run_frame("R10 promisc multicast", rand_mcast(), 0);
        promisc = 1'b0;

        // R3: an aborted frame restarted by sof
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; sof = (i == 0); byte_data = 8'hA5;
        end
        run_frame("R3 restart by sof", station_addr, 0);

        // R6: random table, addresses and modes
        for (int n = 0; n < 80; n++) begin
            for (int w = 0; w < 4; w++)
                if ($urandom_range(0, 3) == 0) wr_word(w, 16'($urandom));
            promisc = ($urandom_range(0, 7) == 0);
            case ($urandom_range(0, 3))
                0: a = station_addr;
                1: begin a = {16'($urandom), 32'($urandom)}; a[0] = 1'b0; end
                default: a = rand_mcast();
            endcase
            run_frame("R6 random frame", a, $urandom_range(0, 2));
        end
        promisc = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule